// File: doc/BRIEF.md
# Multi-Source System Reset Controller

This block generates the internal core reset of a small 8-bit microcontroller. Four sources can start a reset. The first is the external active-low reset pin, taken after the pad's Schmitt trigger. The second is an address-trap detector: it fires when the core fetches an instruction from the RAM and special-register window. The third is a clock-stop detector: it fires when both oscillator enable bits are cleared together. The fourth is a request from the watchdog.

A trap or a clock stop is a fail-safe event. It holds reset for a long, fixed count of clocks. For the whole of that time the controller also pulls the bidirectional reset pin low through an open-drain enable, so the rest of the board sees the reset too. A watchdog request uses the same timed count but leaves the pin alone. An external reset is first filtered for a minimum low width. It then lasts for as long as the pin stays low.

When reset ends, the controller issues two reads to the core, one after the other: first the low byte of the reset vector, then the high byte. The core starts running at that vector. A cause register shows which source started the most recent reset. A read strobe clears it.

Top module: `mcu_reset_ctrl`

## Requirements
- R1: An external reset starts only after `rst_pin_n_i` has been sampled low on EXT_QUAL (default 12) consecutive clock edges. A low run of EXT_QUAL-1 samples or fewer has no effect on `sys_rst_o`.
- R2: Once qualified, the external reset stays active while the pin stays low. It ends one clock after the first high sample. A low run of L samples (L >= EXT_QUAL) gives L-(EXT_QUAL-1) cycles of `sys_rst_o`.
- R3: A fetch with `fetch_valid_i`=1 and `fetch_addr_i` in 0x0000..0x083F starts a reset that begins the cycle after it is sampled. A fetch at 0x0840, or a non-fetch access (`fetch_valid_i`=0) anywhere in the window, has no effect.
- R4: `osc_main_en_i`=0 together with `osc_sub_en_i`=0 starts a reset.
- R5: A trap, clock-stop or watchdog event holds `sys_rst_o` for exactly HOLD_CLKS cycles (default 2^20) after its last event. `pin_drive_o`=1 means "pull the pin low". It is high on exactly those reset cycles that a trap or a clock stop started, and it stays 0 for a watchdog reset.
- R6: A new trap, clock-stop or watchdog event during a timed reset restarts the full HOLD_CLKS count. A condition held for K cycles therefore gives HOLD_CLKS+K-1 reset cycles.
- R7: After every reset, `vec_rd_o` is 1 for two consecutive cycles while `sys_rst_o`=0. `vec_addr_o` is 0xFFFE in the first cycle and 0xFFFF in the second.
- R8: `cause_o` bits are: bit0 external, bit1 address trap, bit2 clock stop, bit3 watchdog. Each new reset event replaces the previous contents.
- R9: A `cause_rd_i` pulse clears `cause_o` on the next cycle. If an event happens in the same cycle, the event wins.
- R10: While `por_i` is high, `sys_rst_o`=1, `pin_drive_o`=0, `vec_rd_o`=0 and `cause_o`=0. After `por_i` falls, the R7 vector reads follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_i | input | 1 | Synchronous active-high power-on reset |
| rst_pin_n_i | input | 1 | Sampled level of the reset pin (low = reset) |
| fetch_valid_i | input | 1 | Current bus cycle is an instruction fetch |
| fetch_addr_i | input | ADDR_W | Bus address |
| osc_main_en_i | input | 1 | High-frequency oscillator enable bit |
| osc_sub_en_i | input | 1 | Low-frequency oscillator enable bit |
| wdt_req_i | input | 1 | Watchdog reset request |
| cause_rd_i | input | 1 | Read strobe that clears the cause register |
| sys_rst_o | output | 1 | Internal core reset, active high |
| pin_drive_o | output | 1 | Open-drain enable that pulls the reset pin low |
| vec_rd_o | output | 1 | Reset-vector read request |
| vec_addr_o | output | ADDR_W | Address of the vector byte being read |
| cause_o | output | 4 | Source of the most recent reset |

## Verification
The assertions check these rules on every cycle:
- a trapping fetch, or both oscillator enables low, puts the core into reset on the next cycle;
- the pin drive never appears outside reset;
- a vector read never overlaps reset, and the low-byte read is followed by the high-byte read;
- a qualified external reset always follows a low pin sample;
- a trap event is always recorded in the cause register.

The exact reset lengths can only be shown by the bench's scenarios: the HOLD_CLKS count, its restart by repeated events, and the L-(EXT_QUAL-1) external length. The same holds for the rejection of short pin pulses, of fetches just outside the trap window and of data accesses inside it, and for the overwrite and clear order of the cause register.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_HOLD = 2'd1,
        ST_VLO  = 2'd2,
        ST_VHI  = 2'd3
    } rst_state_e;

    // One bit per reset source, bit0 = external ... bit3 = watchdog
    typedef struct packed {
        logic wdt;
        logic clk_stop;
        logic trap;
        logic ext;
    } cause_t;

    localparam int CAUSE_W = $bits(cause_t);

    function automatic logic addr_in_window(input int addr, input int lo, input int hi);
        return (addr >= lo) && (addr <= hi);
    endfunction

endpackage

// File: rtl/rstc_ext_filter.sv
module rstc_ext_filter #(
    parameter int QUAL = 12
) (
    input  logic clk,
    input  logic por_i,
    input  logic pin_n_i,
    input  logic mask_i,
    output logic ext_qual_o,
    output logic ext_new_o
);
    localparam int CNT_W = $clog2(QUAL + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(QUAL);
    localparam logic [CNT_W-1:0] CNT_PRE = CNT_W'(QUAL - 1);

    logic [CNT_W-1:0] low_cnt;

    // Count consecutive low samples; the pin is ignored while this block drives it
    always_ff @(posedge clk) begin
        if (por_i || mask_i) begin
            low_cnt <= '0;
        end else if (!pin_n_i) begin
            if (low_cnt != CNT_MAX) low_cnt <= low_cnt + 1'b1;
        end else begin
            low_cnt <= '0;
        end
    end

    assign ext_qual_o = (low_cnt == CNT_MAX);
    assign ext_new_o  = !pin_n_i && !mask_i && (low_cnt == CNT_PRE);

    assert_ext_needs_low_R1: assert property (@(posedge clk) disable iff (por_i)
        ext_qual_o |-> $past(!pin_n_i));

endmodule

// File: rtl/rstc_hold_timer.sv
module rstc_hold_timer #(
    parameter int HOLD = 1 << 20
) (
    input  logic clk,
    input  logic por_i,
    input  logic load_i,
    input  logic set_drive_i,
    output logic busy_o,
    output logic drive_o
);
    localparam int CNT_W = $clog2(HOLD + 1);
    localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(HOLD - 1);

    logic [CNT_W-1:0] cnt;
    logic             drv_q;

    always_ff @(posedge clk) begin
        if (por_i) begin
            cnt <= '0;
        end else if (load_i) begin
            cnt <= LOAD_V;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // Pin drive follows the timed hold that a fail-safe event started
    always_ff @(posedge clk) begin
        if (por_i) begin
            drv_q <= 1'b0;
        end else if (set_drive_i) begin
            drv_q <= 1'b1;
        end else if (cnt == '0) begin
            drv_q <= 1'b0;
        end
    end

    assign busy_o  = (cnt != '0);
    assign drive_o = drv_q;

    assert_drive_released_R5: assert property (@(posedge clk) disable iff (por_i)
        (drv_q && !busy_o && !set_drive_i) |=> !drv_q);

endmodule

// File: rtl/rstc_sequencer.sv
module rstc_sequencer
    import rstc_pkg::*;
(
    input  logic clk,
    input  logic por_i,
    input  logic rst_req_i,
    output logic sys_rst_o,
    output logic vec_rd_o,
    output logic vec_hi_o
);
    rst_state_e st, st_nxt;

    always_comb begin
        st_nxt = st;
        if (rst_req_i) begin
            st_nxt = ST_HOLD;
        end else begin
            unique case (st)
                ST_HOLD: st_nxt = ST_VLO;
                ST_VLO:  st_nxt = ST_VHI;
                ST_VHI:  st_nxt = ST_RUN;
                default: st_nxt = ST_RUN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (por_i) st <= ST_HOLD;
        else       st <= st_nxt;
    end

    assign sys_rst_o = (st == ST_HOLD);
    assign vec_rd_o  = (st == ST_VLO) || (st == ST_VHI);
    assign vec_hi_o  = (st == ST_VHI);

    assert_vec_order_R7: assert property (@(posedge clk) disable iff (por_i)
        (vec_rd_o && !vec_hi_o && !rst_req_i) |=> (vec_rd_o && vec_hi_o));

    assert_vec_outside_reset_R7: assert property (@(posedge clk) disable iff (por_i)
        vec_rd_o |-> !sys_rst_o);

endmodule

// File: rtl/mcu_reset_ctrl.sv
module mcu_reset_ctrl
    import rstc_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int EXT_QUAL  = 12,
    parameter int HOLD_CLKS = 1 << 20,
    parameter int TRAP_LO   = 'h0000,
    parameter int TRAP_HI   = 'h083F,
    parameter int VEC_BASE  = 'hFFFE
) (
    input  logic               clk,
    input  logic               por_i,
    input  logic               rst_pin_n_i,
    input  logic               fetch_valid_i,
    input  logic [ADDR_W-1:0]  fetch_addr_i,
    input  logic               osc_main_en_i,
    input  logic               osc_sub_en_i,
    input  logic               wdt_req_i,
    input  logic               cause_rd_i,
    output logic               sys_rst_o,
    output logic               pin_drive_o,
    output logic               vec_rd_o,
    output logic [ADDR_W-1:0]  vec_addr_o,
    output logic [CAUSE_W-1:0] cause_o
);
    localparam logic [ADDR_W-1:0] VEC_LO_ADDR = ADDR_W'(VEC_BASE);
    localparam logic [ADDR_W-1:0] VEC_HI_ADDR = ADDR_W'(VEC_BASE + 1);

    logic   ext_qual, ext_new;
    logic   trap_evt, clk_evt, timed_evt, failsafe_evt;
    logic   tmr_busy, drv;
    logic   rst_req, vec_hi;
    cause_t evt, cause_q;

    // Event detection
    assign trap_evt     = fetch_valid_i && addr_in_window(int'(fetch_addr_i), TRAP_LO, TRAP_HI);
    assign clk_evt      = !osc_main_en_i && !osc_sub_en_i;
    assign failsafe_evt = trap_evt || clk_evt;
    assign timed_evt    = failsafe_evt || wdt_req_i;

    rstc_ext_filter #(.QUAL(EXT_QUAL)) u_ext (
        .clk        (clk),
        .por_i      (por_i),
        .pin_n_i    (rst_pin_n_i),
        .mask_i     (drv),
        .ext_qual_o (ext_qual),
        .ext_new_o  (ext_new)
    );

    rstc_hold_timer #(.HOLD(HOLD_CLKS)) u_tmr (
        .clk         (clk),
        .por_i       (por_i),
        .load_i      (timed_evt),
        .set_drive_i (failsafe_evt),
        .busy_o      (tmr_busy),
        .drive_o     (drv)
    );

    assign rst_req = ext_qual || tmr_busy || timed_evt;

    rstc_sequencer u_seq (
        .clk       (clk),
        .por_i     (por_i),
        .rst_req_i (rst_req),
        .sys_rst_o (sys_rst_o),
        .vec_rd_o  (vec_rd_o),
        .vec_hi_o  (vec_hi)
    );

    // Cause register: newest event replaces, read clears, event beats read
    always_comb begin
        evt          = '0;
        evt.ext      = ext_new;
        evt.trap     = trap_evt;
        evt.clk_stop = clk_evt;
        evt.wdt      = wdt_req_i;
    end

    always_ff @(posedge clk) begin
        if (por_i)           cause_q <= '0;
        else if (|evt)       cause_q <= evt;
        else if (cause_rd_i) cause_q <= '0;
    end

    assign pin_drive_o = drv;
    assign vec_addr_o  = vec_hi ? VEC_HI_ADDR : VEC_LO_ADDR;
    assign cause_o     = cause_q;

    assert_trap_resets_R3: assert property (@(posedge clk) disable iff (por_i)
        trap_evt |=> sys_rst_o);

    assert_clkstop_drives_R4: assert property (@(posedge clk) disable iff (por_i)
        (!osc_main_en_i && !osc_sub_en_i) |=> (sys_rst_o && pin_drive_o));

    assert_drive_in_reset_R5: assert property (@(posedge clk) disable iff (por_i)
        pin_drive_o |-> sys_rst_o);

    assert_trap_cause_R8: assert property (@(posedge clk) disable iff (por_i)
        trap_evt |=> cause_o[1]);

endmodule

// File: tb/mcu_reset_ctrl_tb_top.sv
module mcu_reset_ctrl_tb_top;
    localparam int HOLD = 20;
    localparam int QUAL = 12;

    logic        clk = 1'b0;
    logic        por_i = 1'b1;
    logic        rst_pin_n_i = 1'b1;
    logic        fetch_valid_i = 1'b0;
    logic [15:0] fetch_addr_i = 16'h1000;
    logic        osc_main_en_i = 1'b1;
    logic        osc_sub_en_i = 1'b1;
    logic        wdt_req_i = 1'b0;
    logic        cause_rd_i = 1'b0;
    logic        sys_rst_o, pin_drive_o, vec_rd_o;
    logic [15:0] vec_addr_o;
    logic [3:0]  cause_o;

    always #2 clk = ~clk;

    mcu_reset_ctrl #(.EXT_QUAL(QUAL), .HOLD_CLKS(HOLD)) dut_i (
        .clk(clk), .por_i(por_i), .rst_pin_n_i(rst_pin_n_i),
        .fetch_valid_i(fetch_valid_i), .fetch_addr_i(fetch_addr_i),
        .osc_main_en_i(osc_main_en_i), .osc_sub_en_i(osc_sub_en_i),
        .wdt_req_i(wdt_req_i), .cause_rd_i(cause_rd_i),
        .sys_rst_o(sys_rst_o), .pin_drive_o(pin_drive_o), .vec_rd_o(vec_rd_o),
        .vec_addr_o(vec_addr_o), .cause_o(cause_o)
    );

    typedef struct {
        int       len;
        int       drv;
        logic [3:0] cause;
        string    req;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0, n_fail = 0;
    bit   mon_en = 0, pend_hi = 0, done = 0;
    int   len_cnt = 0, drv_cnt = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push(input int len, input int drv, input logic [3:0] c, input string req);
        exp_t e;
        e.len = len; e.drv = drv; e.cause = c; e.req = req;
        q.push_back(e);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Monitor: measures each reset and compares against the queued expectation
    always @(negedge clk) begin
        if (mon_en) begin
            if (pend_hi) begin
                check(vec_rd_o && vec_addr_o == 16'hFFFF && !sys_rst_o, "R7",
                      "high vector byte address", int'(vec_addr_o), 'hFFFF);
                pend_hi = 0;
            end else if (vec_rd_o) begin
                exp_t e;
                check(vec_addr_o == 16'hFFFE && !sys_rst_o, "R7",
                      "low vector byte address", int'(vec_addr_o), 'hFFFE);
                pend_hi = 1;
                if (q.size() == 0) begin
                    check(0, "R7", "unexpected reset release", 1, 0);
                end else begin
                    e = q.pop_front();
                    if (e.len >= 0)
                        check(len_cnt == e.len, e.req, "reset length", len_cnt, e.len);
                    check(drv_cnt == e.drv, e.req, "pin drive length R5", drv_cnt, e.drv);
                    check(cause_o == e.cause, e.req, "cause R8", int'(cause_o), int'(e.cause));
                end
                len_cnt = 0;
                drv_cnt = 0;
            end
            if (sys_rst_o)   len_cnt++;
            if (pin_drive_o) drv_cnt++;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(0, "R7", "watchdog expired", 0, 1);
        finish_run();
    end

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic pulse_fetch(input logic [15:0] a, input logic valid);
        @(posedge clk); #1 fetch_valid_i = valid; fetch_addr_i = a;
        @(posedge clk); #1 fetch_valid_i = 1'b0; fetch_addr_i = 16'h1000;
    endtask

    task automatic osc_stop(input int k);
        @(posedge clk); #1 osc_main_en_i = 1'b0; osc_sub_en_i = 1'b0;
        repeat (k) @(posedge clk);
        #1 osc_main_en_i = 1'b1; osc_sub_en_i = 1'b1;
    endtask

    task automatic pin_low(input int n);
        @(posedge clk); #1 rst_pin_n_i = 1'b0;
        repeat (n) @(posedge clk);
        #1 rst_pin_n_i = 1'b1;
    endtask

    task automatic expect_quiet(input string req, input string what);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(!sys_rst_o && !vec_rd_o, req, what, int'(sys_rst_o), 0);
        end
    endtask

    initial begin
        // R10: power-on state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(sys_rst_o == 1'b1, "R10", "sys_rst during por", int'(sys_rst_o), 1);
        check(pin_drive_o == 1'b0 && vec_rd_o == 1'b0, "R10", "drive/vec during por",
              int'({pin_drive_o, vec_rd_o}), 0);
        check(cause_o == 4'h0, "R10", "cause during por", int'(cause_o), 0);
        push(-1, 0, 4'h0, "R10");
        @(posedge clk); #1 por_i = 1'b0; mon_en = 1;
        idle(10);

        // R3: trap at top and bottom of the window
        push(HOLD, HOLD, 4'b0010, "R3");
        pulse_fetch(16'h083F, 1'b1);
        idle(HOLD + 10);
        push(HOLD, HOLD, 4'b0010, "R3");
        pulse_fetch(16'h0000, 1'b1);
        idle(HOLD + 10);

        // R3: just outside, and non-fetch access inside
        pulse_fetch(16'h0840, 1'b1);
        expect_quiet("R3", "fetch at 0x0840");
        pulse_fetch(16'h0100, 1'b0);
        expect_quiet("R3", "data access in window");

        // R4: one-cycle clock stop
        push(HOLD, HOLD, 4'b0100, "R4");
        osc_stop(1);
        idle(HOLD + 10);

        // R6: clock stop held 4 cycles, then two traps 5 cycles apart
        push(HOLD + 3, HOLD + 3, 4'b0100, "R6");
        osc_stop(4);
        idle(HOLD + 10);
        push(HOLD + 5, HOLD + 5, 4'b0010, "R6");
        pulse_fetch(16'h0400, 1'b1);
        idle(3);
        pulse_fetch(16'h0400, 1'b1);
        idle(HOLD + 10);

        // R5: watchdog reset, no pin drive
        push(HOLD, 0, 4'b1000, "R5");
        @(posedge clk); #1 wdt_req_i = 1'b1;
        @(posedge clk); #1 wdt_req_i = 1'b0;
        idle(HOLD + 10);

        // R1: short low pulse ignored
        pin_low(QUAL - 1);
        expect_quiet("R1", "short pin pulse");

        // R2: 20-sample low gives 20-(QUAL-1) reset cycles
        push(20 - (QUAL - 1), 0, 4'b0001, "R2");
        pin_low(20);
        idle(10);

        // R9: read clears cause
        @(negedge clk);
        check(cause_o == 4'b0001, "R8", "cause after external", int'(cause_o), 1);
        @(posedge clk); #1 cause_rd_i = 1'b1;
        @(posedge clk); #1 cause_rd_i = 1'b0;
        @(negedge clk);
        check(cause_o == 4'h0, "R9", "cause after read", int'(cause_o), 0);

        // R9: event in the same cycle as a read wins
        push(HOLD, 0, 4'b1000, "R9");
        @(posedge clk); #1 wdt_req_i = 1'b1; cause_rd_i = 1'b1;
        @(posedge clk); #1 wdt_req_i = 1'b0; cause_rd_i = 1'b0;
        idle(HOLD + 10);

        @(negedge clk);
        check(q.size() == 0, "R7", "outstanding expected releases", q.size(), 0);
        finish_run();
    end
endmodule